// File: doc/BRIEF.md
# Duplicate-Tag Snoop Controller

This block keeps the private L1 data caches of four processor cores coherent under the MESI protocol. It keeps its own shadow copy of every core's tag and state array, one direct-mapped entry per cache line. When a core misses, wants to write a shared line, or evicts a line, it sends a request to the controller. The controller looks up the shadow tags and sends snoop commands only to the cores that actually hold the line.

A miss that another core can satisfy is served from that core's cache instead of from L2. A clean copy is shared. A dirty copy migrates to the requester with ownership, and L2 is not written. L2 sees only two kinds of traffic: reads for lines that no core holds, and write-backs of Modified lines that a core evicts.

Requests from different cores go through a round-robin arbiter, and the controller carries one transaction at a time, so no two operations on the same line ever overlap. Encodings used on the ports:

- Request opcode: 0 read miss, 1 write miss, 2 upgrade, 3 eviction.
- Line state: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified.
- Snoop command: 1 share (return the line, keep or drop to Shared), 2 invalidate, 3 flush (return the line, then go Invalid).

Top module: `scu_top`

## Requirements
- R1: A read miss (opcode 0) on a line that no other core holds reads the line from L2 (one L2 read, no snoop) and grants Exclusive (state 2) with the L2 data and resp_fill = 1.
- R2: A read miss on a line that another core holds in Shared or Exclusive sends a share command (1) to exactly one holder, the lowest-numbered one. It returns that core's data with state Shared (1) and makes no L2 access.
- R3: A read miss on a line that another core holds Modified sends that core a flush command (3) and grants Modified (3) with the flushed data, with no L2 read or write. The former owner's shadow entry becomes Invalid, so a later miss does not snoop it.
- R4: A write miss (opcode 1) grants Modified with resp_fill = 1. If other copies exist, the lowest-numbered holder gets flush (3) and supplies the data, and every other holder gets invalidate (2). Otherwise the line is read from L2.
- R5: An upgrade (opcode 2) from a core whose shadow entry still holds the line invalidates (2) every other holder and grants Modified with resp_fill = 0. If that entry has already been invalidated, the upgrade is served as a write miss with resp_fill = 1.
- R6: An eviction (opcode 3) answers with state Invalid and resp_fill = 0 and sets the shadow entry to Invalid. Only a Modified line causes one L2 write, of the line address and req_wdata. A clean eviction causes no L2 traffic.
- R7: A snoop command never reaches a core whose shadow entry does not hold the addressed line. A line with the same index but a different tag counts as not held. snp_addr carries the line address.
- R8: When several cores request at once, they are accepted one at a time in rotating order, starting from the core after the last one accepted (core 0 first after reset).
- R9: At most one request is accepted per cycle, at most one response is given per cycle, and every accepted request gets exactly one response.
- R10: After reset, all shadow entries are Invalid and no ready, response, snoop or L2 request output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCPU | Per-core request valid |
| req_ready | output | NCPU | Per-core request accepted this cycle |
| req_op | input | NCPU x 2 | Per-core request opcode |
| req_addr | input | NCPU x ADDR_W | Per-core line address |
| req_wdata | input | NCPU x LINE_W | Per-core line data for a dirty eviction |
| resp_valid | output | NCPU | Per-core response strobe |
| resp_state | output | 2 | Granted line state |
| resp_fill | output | 1 | resp_data carries a line |
| resp_data | output | LINE_W | Line data for the requester |
| snp_valid | output | NCPU | Per-core snoop command pending |
| snp_cmd | output | NCPU x 2 | Per-core snoop command |
| snp_addr | output | ADDR_W | Snooped line address |
| snp_ack | input | NCPU | Per-core snoop completion |
| snp_data | input | NCPU x LINE_W | Per-core line returned with the ack |
| l2_req_valid | output | 1 | L2 request strobe |
| l2_req_we | output | 1 | L2 request is a write-back |
| l2_addr | output | ADDR_W | L2 line address |
| l2_wdata | output | LINE_W | L2 write-back data |
| l2_rvalid | input | 1 | L2 read data valid |
| l2_rdata | input | LINE_W | L2 read data |

## Verification
The bench moves one line through every MESI transition: exclusive fill, sharing, a write miss that flushes one holder and invalidates another, and two dirty migrations in a row. A controller that fails to clear the previous owner would snoop a stale core on the second migration. It also sends an upgrade from a core whose copy was invalidated while the core waited. A design that took this case as a plain upgrade would grant Modified without data. An index alias with a different tag must not be snooped, and a design that skipped the tag compare would snoop it. Clean and dirty evictions are checked so that only the dirty one writes L2, and four simultaneous requests must be answered in rotating order.

// File: rtl/scu_pkg.sv
package scu_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_UPGRADE = 2'd2,
        OP_EVICT   = 2'd3
    } scu_op_e;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [1:0] {
        SN_NONE  = 2'd0,
        SN_SHARE = 2'd1,
        SN_INVAL = 2'd2,
        SN_FLUSH = 2'd3
    } snp_cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_EVAL   = 3'd1,
        PH_SNOOP  = 3'd2,
        PH_L2RD   = 3'd3,
        PH_L2WAIT = 3'd4,
        PH_L2WR   = 3'd5,
        PH_RESP   = 3'd6
    } phase_e;

endpackage

// File: rtl/scu_rr_arb.sv
module scu_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 take,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gnt_idx,
    output logic                 any
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [IW-1:0] last;
    } arb_t;

    arb_t q, d;

    // Search starts one past the last winner and wraps around.
    always_comb begin
        logic found;
        found   = 1'b0;
        gnt     = '0;
        gnt_idx = '0;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = (int'(q.last) + k) % N;
            if (!found && req[cand]) begin
                found        = 1'b1;
                gnt[cand]    = 1'b1;
                gnt_idx      = IW'(cand);
            end
        end
        any    = found;
        d      = q;
        if (take && found) begin
            d.last = gnt_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.last <= IW'(N - 1);
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/scu_dup_tag.sv
module scu_dup_tag
    import scu_pkg::*;
#(
    parameter int LINES = 64,
    parameter int TAG_W = 21
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] lk_idx,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic                     lk_hit,
    output logic [1:0]               lk_state,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic [1:0]               wr_state
);
    localparam int IW = $clog2(LINES);

    logic [TAG_W-1:0] tag_q [LINES];
    logic [TAG_W-1:0] tag_d [LINES];
    logic [1:0]       st_q  [LINES];
    logic [1:0]       st_d  [LINES];

    always_comb begin
        tag_d = tag_q;
        st_d  = st_q;
        if (wr_en) begin
            tag_d[wr_idx] = wr_tag;
            st_d[wr_idx]  = wr_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= ST_I;
            end
        end else begin
            tag_q <= tag_d;
            st_q  <= st_d;
        end
    end

    assign lk_state = st_q[lk_idx];
    assign lk_hit   = (st_q[lk_idx] != ST_I) && (tag_q[lk_idx] == lk_tag);

endmodule

// File: rtl/scu_top.sv
module scu_top
    import scu_pkg::*;
#(
    parameter int NCPU       = 4,
    parameter int LINES      = 64,
    parameter int LINE_BYTES = 32,
    parameter int ADDR_W     = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NCPU-1:0]                   req_valid,
    output logic [NCPU-1:0]                   req_ready,
    input  logic [NCPU-1:0][1:0]              req_op,
    input  logic [NCPU-1:0][ADDR_W-1:0]       req_addr,
    input  logic [NCPU-1:0][LINE_BYTES*8-1:0] req_wdata,
    output logic [NCPU-1:0]                   resp_valid,
    output logic [1:0]                        resp_state,
    output logic                              resp_fill,
    output logic [LINE_BYTES*8-1:0]           resp_data,
    output logic [NCPU-1:0]                   snp_valid,
    output logic [NCPU-1:0][1:0]              snp_cmd,
    output logic [ADDR_W-1:0]                 snp_addr,
    input  logic [NCPU-1:0]                   snp_ack,
    input  logic [NCPU-1:0][LINE_BYTES*8-1:0] snp_data,
    output logic                              l2_req_valid,
    output logic                              l2_req_we,
    output logic [ADDR_W-1:0]                 l2_addr,
    output logic [LINE_BYTES*8-1:0]           l2_wdata,
    input  logic                              l2_rvalid,
    input  logic [LINE_BYTES*8-1:0]           l2_rdata
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int CW     = (NCPU > 1) ? $clog2(NCPU) : 1;

    typedef struct packed {
        phase_e                 ph;
        logic [CW-1:0]          cpu;
        scu_op_e                op;
        logic [TAG_W-1:0]       tag;
        logic [IDX_W-1:0]       idx;
        logic [LINE_W-1:0]      data;
        logic [NCPU-1:0]        pend;
        logic [NCPU-1:0][1:0]   cmd;
        logic [CW-1:0]          src;
        mesi_e                  nst;
        logic                   fill;
    } ctl_t;

    ctl_t q, d;

    // Arbiter
    logic [NCPU-1:0] gnt;
    logic [CW-1:0]   gnt_idx;
    logic            any_req;
    logic            take;

    scu_rr_arb #(.N(NCPU)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .take    (take),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .any     (any_req)
    );

    // Shadow tag banks, one per core
    logic [NCPU-1:0]      hit_vec;
    logic [NCPU-1:0][1:0] lk_st;
    logic [NCPU-1:0]      wr_en;
    logic [NCPU-1:0][1:0] wr_st;

    for (genvar g = 0; g < NCPU; g++) begin : g_bank
        scu_dup_tag #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_idx   (q.idx),
            .lk_tag   (q.tag),
            .lk_hit   (hit_vec[g]),
            .lk_state (lk_st[g]),
            .wr_en    (wr_en[g]),
            .wr_idx   (q.idx),
            .wr_tag   (q.tag),
            .wr_state (wr_st[g])
        );
    end

    function automatic logic [CW-1:0] lowest(input logic [NCPU-1:0] m);
        lowest = '0;
        for (int j = NCPU - 1; j >= 0; j--) begin
            if (m[j]) lowest = CW'(j);
        end
    endfunction

    logic [NCPU-1:0] self_mask;
    logic [NCPU-1:0] others;
    logic [CW-1:0]   src_sel;
    logic [ADDR_W-1:0] sel_addr;

    assign self_mask = NCPU'(1) << q.cpu;
    assign others    = hit_vec & ~self_mask;
    assign src_sel   = lowest(others);
    assign sel_addr  = req_addr[gnt_idx];

    always_comb begin
        d    = q;
        take = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (any_req) begin
                    take   = 1'b1;
                    d.cpu  = gnt_idx;
                    d.op   = scu_op_e'(req_op[gnt_idx]);
                    d.tag  = sel_addr[ADDR_W-1 -: TAG_W];
                    d.idx  = sel_addr[OFF_W +: IDX_W];
                    d.data = req_wdata[gnt_idx];
                    d.pend = '0;
                    d.cmd  = '0;
                    d.fill = 1'b0;
                    d.src  = '0;
                    d.ph   = PH_EVAL;
                end
            end
            PH_EVAL: begin
                d.src = src_sel;
                unique case (q.op)
                    OP_EVICT: begin
                        d.nst = ST_I;
                        d.ph  = (hit_vec[q.cpu] && lk_st[q.cpu] == ST_M) ? PH_L2WR : PH_RESP;
                    end
                    OP_READ: begin
                        d.fill = 1'b1;
                        if (|others) begin
                            d.pend = NCPU'(1) << src_sel;
                            if (lk_st[src_sel] == ST_M) begin
                                d.cmd[src_sel] = SN_FLUSH;
                                d.nst          = ST_M;
                            end else begin
                                d.cmd[src_sel] = SN_SHARE;
                                d.nst          = ST_S;
                            end
                            d.ph = PH_SNOOP;
                        end else begin
                            d.nst = ST_E;
                            d.ph  = PH_L2RD;
                        end
                    end
                    default: begin
                        d.nst = ST_M;
                        for (int j = 0; j < NCPU; j++) begin
                            if (others[j]) d.cmd[j] = SN_INVAL;
                        end
                        d.pend = others;
                        if (q.op == OP_UPGRADE && hit_vec[q.cpu]) begin
                            d.fill = 1'b0;
                            d.ph   = (|others) ? PH_SNOOP : PH_RESP;
                        end else begin
                            d.fill = 1'b1;
                            if (|others) begin
                                d.cmd[src_sel] = SN_FLUSH;
                                d.ph           = PH_SNOOP;
                            end else begin
                                d.ph = PH_L2RD;
                            end
                        end
                    end
                endcase
            end
            PH_SNOOP: begin
                for (int j = 0; j < NCPU; j++) begin
                    if (q.pend[j] && snp_ack[j]) begin
                        d.pend[j] = 1'b0;
                        if (CW'(j) == q.src && q.fill) d.data = snp_data[j];
                    end
                end
                if ((q.pend & ~snp_ack) == '0) d.ph = PH_RESP;
            end
            PH_L2RD:   d.ph = PH_L2WAIT;
            PH_L2WAIT: begin
                if (l2_rvalid) begin
                    d.data = l2_rdata;
                    d.ph   = PH_RESP;
                end
            end
            PH_L2WR:   d.ph = PH_RESP;
            PH_RESP:   d.ph = PH_IDLE;
            default:   d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Shadow tag update at response time
    always_comb begin
        for (int j = 0; j < NCPU; j++) begin
            wr_en[j] = (q.ph == PH_RESP) && ((CW'(j) == q.cpu) || (q.cmd[j] != SN_NONE));
            if (CW'(j) == q.cpu)             wr_st[j] = q.nst;
            else if (q.cmd[j] == SN_SHARE)   wr_st[j] = ST_S;
            else                             wr_st[j] = ST_I;
        end
    end

    // Outputs
    logic [ADDR_W-1:0] line_addr;
    assign line_addr = {q.tag, q.idx, {OFF_W{1'b0}}};

    assign req_ready    = (q.ph == PH_IDLE) ? gnt : '0;
    assign resp_valid   = (q.ph == PH_RESP) ? self_mask : '0;
    assign resp_state   = q.nst;
    assign resp_fill    = q.fill;
    assign resp_data    = q.data;
    assign snp_valid    = (q.ph == PH_SNOOP) ? q.pend : '0;
    assign snp_cmd      = q.cmd;
    assign snp_addr     = line_addr;
    assign l2_req_valid = (q.ph == PH_L2RD) || (q.ph == PH_L2WR);
    assign l2_req_we    = (q.ph == PH_L2WR);
    assign l2_addr      = line_addr;
    assign l2_wdata     = q.data;

    logic [1:0] cur_op;
    assign cur_op = q.op;

endmodule

// File: rtl/scu_checker.sv
module scu_checker
    import scu_pkg::*;
#(
    parameter int NCPU = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCPU-1:0] req_ready,
    input logic [NCPU-1:0] resp_valid,
    input logic [NCPU-1:0] snp_valid,
    input logic [NCPU-1:0] hit_vec,
    input logic            l2_req_valid,
    input logic            l2_req_we,
    input logic [1:0]      cur_op
);

    a_r9_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(resp_valid) <= 1);

    a_r8_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    a_r9_no_accept_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (|resp_valid) |-> (req_ready == '0));

    a_r7_snoop_holders_only: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid & ~hit_vec) == '0);

    a_r6_l2_write_on_evict: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req_valid && l2_req_we) |-> (cur_op == OP_EVICT));

    a_r2_no_l2_while_snooping: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req_valid |-> (snp_valid == '0));

    a_r10_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (resp_valid == '0 && snp_valid == '0 && !l2_req_valid));

endmodule

bind scu_top scu_checker #(.NCPU(NCPU)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .snp_valid    (snp_valid),
    .hit_vec      (hit_vec),
    .l2_req_valid (l2_req_valid),
    .l2_req_we    (l2_req_we),
    .cur_op       (cur_op)
);

// File: tb/scu_top_tb.sv
`timescale 1ns/1ps
module scu_top_tb;
    localparam int NCPU = 4;
    localparam int AW   = 32;
    localparam int LW   = 256;

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, UP = 2'd2, EV = 2'd3;
    localparam logic [1:0] SI = 2'd0, SS = 2'd1, SE = 2'd2, SM = 2'd3;
    localparam logic [1:0] CN = 2'd0, CSH = 2'd1, CIV = 2'd2, CFL = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NCPU-1:0]          req_valid = '0;
    logic [NCPU-1:0]          req_ready;
    logic [NCPU-1:0][1:0]     req_op = '0;
    logic [NCPU-1:0][AW-1:0]  req_addr = '0;
    logic [NCPU-1:0][LW-1:0]  req_wdata = '0;
    logic [NCPU-1:0]          resp_valid;
    logic [1:0]               resp_state;
    logic                     resp_fill;
    logic [LW-1:0]            resp_data;
    logic [NCPU-1:0]          snp_valid;
    logic [NCPU-1:0][1:0]     snp_cmd;
    logic [AW-1:0]            snp_addr;
    logic [NCPU-1:0]          snp_ack = '0;
    logic [NCPU-1:0][LW-1:0]  snp_data = '0;
    logic                     l2_req_valid;
    logic                     l2_req_we;
    logic [AW-1:0]            l2_addr;
    logic [LW-1:0]            l2_wdata;
    logic                     l2_rvalid = 1'b0;
    logic [LW-1:0]            l2_rdata = '0;

    scu_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_state(resp_state), .resp_fill(resp_fill),
        .resp_data(resp_data),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_ack(snp_ack), .snp_data(snp_data),
        .l2_req_valid(l2_req_valid), .l2_req_we(l2_req_we), .l2_addr(l2_addr),
        .l2_wdata(l2_wdata), .l2_rvalid(l2_rvalid), .l2_rdata(l2_rdata)
    );

    function automatic logic [LW-1:0] l2_line(input logic [AW-1:0] a);
        return {8{a ^ 32'hA5A5_0000}};
    endfunction

    function automatic logic [LW-1:0] cpu_line(input int c, input logic [AW-1:0] a);
        return {8{a ^ (32'(c + 1) << 24)}};
    endfunction

    function automatic logic [7:0] snp4(input logic [1:0] c0, input logic [1:0] c1,
                                        input logic [1:0] c2, input logic [1:0] c3);
        return {c3, c2, c1, c0};
    endfunction

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Scoreboard
    typedef struct {
        int          cpu;
        logic [1:0]  st;
        logic        fill;
        logic [LW-1:0] data;
        string       rq;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;

    always @(negedge clk) begin
        if (rst_n && (|resp_valid)) begin
            chk($countones(resp_valid) == 1, "R9", 64'(resp_valid), 64'd1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", 64'(resp_valid), 64'd0);
            end else begin
                mon_e = exp_q.pop_front();
                chk(resp_valid == (NCPU'(1) << mon_e.cpu), mon_e.rq, 64'(resp_valid), 64'(NCPU'(1) << mon_e.cpu));
                chk(resp_state == mon_e.st, mon_e.rq, 64'(resp_state), 64'(mon_e.st));
                chk(resp_fill == mon_e.fill, mon_e.rq, 64'(resp_fill), 64'(mon_e.fill));
                if (mon_e.fill)
                    chk(resp_data == mon_e.data, mon_e.rq, resp_data[63:0], mon_e.data[63:0]);
            end
        end
    end

    // Core snoop responders
    logic [NCPU-1:0][1:0] snp_log = '0;
    logic [AW-1:0]        snp_log_addr = '0;
    int scnt [NCPU];

    initial for (int j = 0; j < NCPU; j++) scnt[j] = 0;

    always @(negedge clk) begin
        for (int j = 0; j < NCPU; j++) begin
            if (snp_ack[j]) begin
                snp_ack[j] = 1'b0;
            end else if (snp_valid[j]) begin
                if (scnt[j] == 0) begin
                    snp_log[j]   = snp_cmd[j];
                    snp_log_addr = snp_addr;
                end
                if (scnt[j] == 2) begin
                    snp_ack[j]  = 1'b1;
                    snp_data[j] = cpu_line(j, snp_addr);
                    scnt[j]     = 0;
                end else begin
                    scnt[j]++;
                end
            end
        end
    end

    // L2 model
    int n_l2rd = 0;
    int n_l2wr = 0;
    int l2_wait = 0;
    logic [AW-1:0] l2_rd_addr = '0;
    logic [AW-1:0] l2_wr_addr = '0;
    logic [LW-1:0] l2_wr_data = '0;

    always @(negedge clk) begin
        if (l2_rvalid) l2_rvalid = 1'b0;
        if (l2_req_valid) begin
            if (l2_req_we) begin
                n_l2wr++;
                l2_wr_addr = l2_addr;
                l2_wr_data = l2_wdata;
            end else begin
                n_l2rd++;
                l2_rd_addr = l2_addr;
                l2_wait    = 3;
            end
        end else if (l2_wait > 0) begin
            l2_wait--;
            if (l2_wait == 0) begin
                l2_rvalid = 1'b1;
                l2_rdata  = l2_line(l2_rd_addr);
            end
        end
    end

    // Driver
    int last_cpu = NCPU - 1;

    task automatic drive(input int c, input logic [1:0] op, input logic [AW-1:0] a, input logic [LW-1:0] w);
        req_op[c]    = op;
        req_addr[c]  = a;
        req_wdata[c] = w;
        req_valid[c] = 1'b1;
        #1;
        while (!req_ready[c]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        req_valid[c] = 1'b0;
    endtask

    task automatic txn(input int c, input logic [1:0] op, input logic [AW-1:0] a, input logic [LW-1:0] w,
                       input logic [1:0] est, input logic ef, input logic [LW-1:0] ed,
                       input logic [7:0] esnp, input int erd, input int ewr, input string rq);
        int rd0, wr0;
        exp_t e;
        @(negedge clk);
        snp_log = '0;
        snp_log_addr = '0;
        rd0 = n_l2rd;
        wr0 = n_l2wr;
        e.cpu = c; e.st = est; e.fill = ef; e.data = ed; e.rq = rq;
        exp_q.push_back(e);
        drive(c, op, a, w);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(snp_log == esnp, rq, 64'(snp_log), 64'(esnp));
        if (esnp != 0) chk(snp_log_addr == a, rq, 64'(snp_log_addr), 64'(a));
        chk(n_l2rd - rd0 == erd, rq, 64'(n_l2rd - rd0), 64'(erd));
        chk(n_l2wr - wr0 == ewr, rq, 64'(n_l2wr - wr0), 64'(ewr));
        last_cpu = c;
    endtask

    localparam logic [AW-1:0] A_ADDR  = 32'h0000_1000;
    localparam logic [AW-1:0] AL_ADDR = 32'h0000_1800;
    localparam logic [AW-1:0] B_ADDR  = 32'h0000_2040;
    localparam logic [AW-1:0] C_ADDR  = 32'h0000_3080;
    localparam logic [AW-1:0] F_ADDR  = 32'h0000_5000;
    localparam logic [LW-1:0] EV_DATA = {8{32'hDEAD_BEEF}};

    function automatic logic [AW-1:0] d_addr(input int c);
        return 32'h0000_4100 + 32'(c * 32);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: quiet outputs after reset
        chk(resp_valid == '0, "R10", 64'(resp_valid), 64'd0);
        chk(snp_valid == '0, "R10", 64'(snp_valid), 64'd0);
        chk(l2_req_valid == 1'b0, "R10", 64'(l2_req_valid), 64'd0);
        chk(req_ready == '0, "R10", 64'(req_ready), 64'd0);

        // R1 (and R10: nothing valid in the shadow tags)
        txn(0, RD, A_ADDR, '0, SE, 1'b1, l2_line(A_ADDR), snp4(CN, CN, CN, CN), 1, 0, "R1");
        // R2: clean line shared from core 0
        txn(1, RD, A_ADDR, '0, SS, 1'b1, cpu_line(0, A_ADDR), snp4(CSH, CN, CN, CN), 0, 0, "R2");
        // R4: write miss, core 0 flushes, core 1 invalidated
        txn(2, WR, A_ADDR, '0, SM, 1'b1, cpu_line(0, A_ADDR), snp4(CFL, CIV, CN, CN), 0, 0, "R4");
        // R3: dirty migration from core 2
        txn(3, RD, A_ADDR, '0, SM, 1'b1, cpu_line(2, A_ADDR), snp4(CN, CN, CFL, CN), 0, 0, "R3");
        // R3: second migration, core 2 must no longer be snooped
        txn(0, RD, A_ADDR, '0, SM, 1'b1, cpu_line(3, A_ADDR), snp4(CN, CN, CN, CFL), 0, 0, "R3");
        // R5: upgrade from a core whose copy was lost
        txn(1, UP, A_ADDR, '0, SM, 1'b1, cpu_line(0, A_ADDR), snp4(CFL, CN, CN, CN), 0, 0, "R5");
        // R7: same index, different tag is not a hit
        txn(2, RD, AL_ADDR, '0, SE, 1'b1, l2_line(AL_ADDR), snp4(CN, CN, CN, CN), 1, 0, "R7");
        txn(2, RD, B_ADDR, '0, SE, 1'b1, l2_line(B_ADDR), snp4(CN, CN, CN, CN), 1, 0, "R1");
        txn(3, RD, B_ADDR, '0, SS, 1'b1, cpu_line(2, B_ADDR), snp4(CN, CN, CSH, CN), 0, 0, "R2");
        // R5: true upgrade, no data
        txn(3, UP, B_ADDR, '0, SM, 1'b0, '0, snp4(CN, CN, CIV, CN), 0, 0, "R5");
        // R6: dirty eviction writes L2
        txn(3, EV, B_ADDR, EV_DATA, SI, 1'b0, '0, snp4(CN, CN, CN, CN), 0, 1, "R6");
        chk(l2_wr_addr == B_ADDR, "R6", 64'(l2_wr_addr), 64'(B_ADDR));
        chk(l2_wr_data == EV_DATA, "R6", l2_wr_data[63:0], EV_DATA[63:0]);
        // R6: evicted line no longer held anywhere
        txn(0, RD, B_ADDR, '0, SE, 1'b1, l2_line(B_ADDR), snp4(CN, CN, CN, CN), 1, 0, "R6");
        txn(2, RD, C_ADDR, '0, SE, 1'b1, l2_line(C_ADDR), snp4(CN, CN, CN, CN), 1, 0, "R1");
        // R6: clean eviction, no L2 traffic
        txn(2, EV, C_ADDR, '0, SI, 1'b0, '0, snp4(CN, CN, CN, CN), 0, 0, "R6");
        txn(1, RD, C_ADDR, '0, SE, 1'b1, l2_line(C_ADDR), snp4(CN, CN, CN, CN), 1, 0, "R6");
        // R4: write miss with no holders
        txn(0, WR, F_ADDR, '0, SM, 1'b1, l2_line(F_ADDR), snp4(CN, CN, CN, CN), 1, 0, "R4");

        // R8: four simultaneous requests, rotating order
        begin
            int rd0;
            @(negedge clk);
            snp_log = '0;
            rd0 = n_l2rd;
            for (int k = 1; k <= NCPU; k++) begin
                exp_t e;
                e.cpu  = (last_cpu + k) % NCPU;
                e.st   = SE;
                e.fill = 1'b1;
                e.data = l2_line(d_addr(e.cpu));
                e.rq   = "R8";
                exp_q.push_back(e);
            end
            fork
                drive(0, RD, d_addr(0), '0);
                drive(1, RD, d_addr(1), '0);
                drive(2, RD, d_addr(2), '0);
                drive(3, RD, d_addr(3), '0);
            join
            while (exp_q.size() != 0) @(negedge clk);
            @(negedge clk);
            chk(n_l2rd - rd0 == NCPU, "R8", 64'(n_l2rd - rd0), 64'(NCPU));
            chk(snp_log == '0, "R8", 64'(snp_log), 64'd0);
        end

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9", 64'(exp_q.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule